// File: doc/BRIEF.md
# Table Jump Execution Unit

This unit carries out the compressed table-jump instruction of a RISC-V style core. It decodes one 16-bit instruction word, takes an 8-bit index from it and reads one pointer-sized entry from a jump table in instruction memory. It then returns the entry, with bit 0 cleared, as the redirect target. Indexes of 32 and above select the linking form, which also writes the return address (PC + 2) into x1. The unit holds the jump-table CSR, whose low six bits are a mode field and whose remaining bits give the table base.

Instructions reach the unit over a valid/ready stream. `ins_ready` is high only while the unit is idle, so at most one jump is in flight. A word is consumed when `ins_valid` and `ins_ready` are both high on a rising edge. The upstream side must hold the word and PC stable until that edge.

The memory request is also a valid/ready stream. `mem_req_valid` and `mem_req_addr` stay constant until `mem_req_ready` accepts them. The response side has `mem_rsp_ready`, which is high while a response is awaited. Results appear as one-cycle pulses on the redirect, register-write and exception outputs. Two plain inputs gate the unit: one enables the extension, and the other carries the state-enable bit together with whether the current privilege mode needs that bit.

Top module: `tbljmp_unit`

## Requirements
- R1: A word is a table jump when bits [15:13] = 101, bits [12:10] = 000 and bits [1:0] = 10. Its index is bits [9:2]. Any other word is accepted and causes no memory request and no output pulse.
- R2: The CSR sits at address 0x017. A request gets a response (`csr_resp`) one cycle later. A write stores the full `csr_wdata`. A read returns the value held before the request. Requests to other addresses get no response and change nothing.
- R3: The table address is the CSR value with bits [5:0] cleared, plus index × (XLEN/8). While `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` stay stable.
- R4: The cycle after a fault-free response, `redir_valid` pulses for exactly one cycle. `redir_pc` carries the response data with bit 0 cleared.
- R5: For an index of 32 or more, `rf_we` pulses in the same cycle as the redirect, with `rf_waddr` = 1 and `rf_wdata` = PC + 2. Indexes below 32 produce no register write.
- R6: A table jump with a nonzero CSR mode field (bits [5:0]) raises `exc_valid` with cause 2 (illegal instruction) and `exc_pc` = PC. It makes no memory request and no redirect.
- R7: With `ext_en` low, a CSR request responds with `csr_fault` = 1 and read data 0 and leaves the CSR unchanged. A table jump raises cause 2 without any memory request.
- R8: With `se_required` high and `se_bit` low, CSR requests and table jumps are rejected exactly as in R7.
- R9: A response with `mem_rsp_err` high raises `exc_valid` with cause 1 (instruction access fault) and `exc_pc` = PC of the jump. It produces no redirect and no register write.
- R10: From acceptance of a table jump until its result pulse, `busy` is high and `ins_ready` is low.
- R11: After reset the CSR is 0, `ins_ready` is high, `busy` is low and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_en | input | 1 | Extension enable |
| se_required | input | 1 | Current mode requires the state-enable bit |
| se_bit | input | 1 | State-enable bit for the jump table |
| ins_valid | input | 1 | Instruction word valid |
| ins_ready | output | 1 | Unit idle, can accept a word |
| ins_word | input | 16 | Compressed instruction word |
| ins_pc | input | XLEN | PC of the instruction |
| csr_req | input | 1 | CSR access request |
| csr_wr | input | 1 | Request is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_resp | output | 1 | Response pulse for the CSR |
| csr_rdata | output | XLEN | CSR read data |
| csr_fault | output | 1 | Access rejected |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | XLEN | Table entry address |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Unit awaits a response |
| mem_rsp_data | input | XLEN | Table entry |
| mem_rsp_err | input | 1 | Access fault on the read |
| redir_valid | output | 1 | Redirect pulse |
| redir_pc | output | XLEN | Jump target |
| rf_we | output | 1 | Register write pulse |
| rf_waddr | output | 5 | Register index (always 1) |
| rf_wdata | output | XLEN | Return address |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 4 | 1 = access fault, 2 = illegal |
| exc_pc | output | XLEN | PC of the faulting jump |
| busy | output | 1 | Jump in flight |

## Verification
The hardest case to reach is a jump that meets back-pressure on the memory request and then a slow response. Requirements R3 and R10 only show themselves there. The memory model in the bench therefore holds `mem_req_ready` low for a set number of cycles and then delays the response. The bench checks that the address stays put and that no second word is accepted meanwhile. Fault responses and the gating inputs are combined with the same jumps. Each rejected case must then show the CSR value intact on a later read.

// File: rtl/tbljmp_pkg.sv
package tbljmp_pkg;
  localparam logic [11:0] TJ_CSR_ADDR  = 12'h017;
  localparam int          MODE_W       = 6;
  localparam int          IDX_W        = 8;
  localparam int          LINK_MIN     = 32;
  localparam int          CAUSE_W      = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_FETCH_FAULT = 4'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL     = 4'd2;
  localparam logic [4:0]  LINK_REG     = 5'd1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } tj_state_e;
endpackage

// File: rtl/tbljmp_csr.sv
module tbljmp_csr
  import tbljmp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            allowed,
  input  logic            csr_req,
  input  logic            csr_wr,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic            csr_resp,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_fault,
  output logic [XLEN-1:0] tbl_csr
);
  logic            hit;
  logic [XLEN-1:0] csr_q;

  assign hit     = csr_req && (csr_addr == TJ_CSR_ADDR);
  assign tbl_csr = csr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q     <= '0;
      csr_resp  <= 1'b0;
      csr_rdata <= '0;
      csr_fault <= 1'b0;
    end else begin
      csr_resp  <= hit;
      csr_fault <= hit && !allowed;
      csr_rdata <= (hit && allowed) ? csr_q : '0;
      if (hit && allowed && csr_wr) csr_q <= csr_wdata;
    end
  end

  assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && !allowed) |=> $stable(csr_q));
  assert_miss_no_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_req) |=> !csr_resp);
endmodule

// File: rtl/tbljmp_decode.sv
module tbljmp_decode
  import tbljmp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [15:0]     word,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] tbl_csr,
  output logic            is_tj,
  output logic            link,
  output logic            mode_bad,
  output logic [XLEN-1:0] tbl_addr,
  output logic [XLEN-1:0] ret_addr
);
  localparam int ENTRY_BYTES = XLEN / 8;
  localparam int SHIFT       = $clog2(ENTRY_BYTES);

  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  base;
  logic [XLEN-1:0]  offset;

  assign is_tj    = (word[15:13] == 3'b101) && (word[12:10] == 3'b000) && (word[1:0] == 2'b10);
  assign idx      = word[9:2];
  assign link     = (idx >= IDX_W'(LINK_MIN));
  assign mode_bad = (tbl_csr[MODE_W-1:0] != '0);
  assign base     = {tbl_csr[XLEN-1:MODE_W], {MODE_W{1'b0}}};
  assign ret_addr = pc + XLEN'(2);

  generate
    if (XLEN == 32 || XLEN == 64) begin : g_stride
      assign offset = XLEN'(idx) << SHIFT;
    end else begin : g_bad_xlen
      assign offset = '0;
      initial $error("tbljmp_decode: XLEN must be 32 or 64");
    end
  endgenerate

  assign tbl_addr = base + offset;
endmodule

// File: rtl/tbljmp_seq.sv
module tbljmp_seq
  import tbljmp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               allowed,
  input  logic               ins_valid,
  output logic               ins_ready,
  input  logic [XLEN-1:0]    ins_pc,
  input  logic               is_tj,
  input  logic               link,
  input  logic               mode_bad,
  input  logic [XLEN-1:0]    tbl_addr,
  input  logic [XLEN-1:0]    ret_addr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [XLEN-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [XLEN-1:0]    mem_rsp_data,
  input  logic               mem_rsp_err,
  output logic               redir_valid,
  output logic [XLEN-1:0]    redir_pc,
  output logic               rf_we,
  output logic [4:0]         rf_waddr,
  output logic [XLEN-1:0]    rf_wdata,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_pc,
  output logic               busy
);
  tj_state_e       state_q;
  logic [XLEN-1:0] pc_q, addr_q, ret_q;
  logic            link_q;
  logic            take;

  assign ins_ready     = (state_q == ST_IDLE);
  assign busy          = (state_q != ST_IDLE);
  assign take          = ins_valid && ins_ready && is_tj;
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = (state_q == ST_WAIT);
  assign rf_waddr      = LINK_REG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pc_q        <= '0;
      addr_q      <= '0;
      ret_q       <= '0;
      link_q      <= 1'b0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      rf_we       <= 1'b0;
      rf_wdata    <= '0;
      exc_valid   <= 1'b0;
      exc_cause   <= '0;
      exc_pc      <= '0;
    end else begin
      redir_valid <= 1'b0;
      rf_we       <= 1'b0;
      exc_valid   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            if (!allowed || mode_bad) begin
              exc_valid <= 1'b1;
              exc_cause <= CAUSE_ILLEGAL;
              exc_pc    <= ins_pc;
            end else begin
              pc_q    <= ins_pc;
              addr_q  <= tbl_addr;
              ret_q   <= ret_addr;
              link_q  <= link;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            state_q <= ST_IDLE;
            if (mem_rsp_err) begin
              exc_valid <= 1'b1;
              exc_cause <= CAUSE_FETCH_FAULT;
              exc_pc    <= pc_q;
            end else begin
              redir_valid <= 1'b1;
              redir_pc    <= {mem_rsp_data[XLEN-1:1], 1'b0};
              rf_we       <= link_q;
              rf_wdata    <= ret_q;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  assert_redir_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid);
  assert_link_with_redir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> redir_valid);
  assert_fault_no_redir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!redir_valid && !rf_we));
  assert_single_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ins_ready);
  assert_illegal_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (mode_bad || !allowed)) |=> !mem_req_valid);
endmodule

// File: rtl/tbljmp_unit.sv
module tbljmp_unit
  import tbljmp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_en,
  input  logic               se_required,
  input  logic               se_bit,
  input  logic               ins_valid,
  output logic               ins_ready,
  input  logic [15:0]        ins_word,
  input  logic [XLEN-1:0]    ins_pc,
  input  logic               csr_req,
  input  logic               csr_wr,
  input  logic [11:0]        csr_addr,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic               csr_resp,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               csr_fault,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [XLEN-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [XLEN-1:0]    mem_rsp_data,
  input  logic               mem_rsp_err,
  output logic               redir_valid,
  output logic [XLEN-1:0]    redir_pc,
  output logic               rf_we,
  output logic [4:0]         rf_waddr,
  output logic [XLEN-1:0]    rf_wdata,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_pc,
  output logic               busy
);
  logic            allowed;
  logic [XLEN-1:0] tbl_csr, tbl_addr, ret_addr;
  logic            is_tj, link, mode_bad;

  assign allowed = ext_en && !(se_required && !se_bit);

  tbljmp_csr #(.XLEN(XLEN)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .allowed   (allowed),
    .csr_req   (csr_req),
    .csr_wr    (csr_wr),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_resp  (csr_resp),
    .csr_rdata (csr_rdata),
    .csr_fault (csr_fault),
    .tbl_csr   (tbl_csr)
  );

  tbljmp_decode #(.XLEN(XLEN)) u_dec (
    .word     (ins_word),
    .pc       (ins_pc),
    .tbl_csr  (tbl_csr),
    .is_tj    (is_tj),
    .link     (link),
    .mode_bad (mode_bad),
    .tbl_addr (tbl_addr),
    .ret_addr (ret_addr)
  );

  tbljmp_seq #(.XLEN(XLEN)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .allowed       (allowed),
    .ins_valid     (ins_valid),
    .ins_ready     (ins_ready),
    .ins_pc        (ins_pc),
    .is_tj         (is_tj),
    .link          (link),
    .mode_bad      (mode_bad),
    .tbl_addr      (tbl_addr),
    .ret_addr      (ret_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_err   (mem_rsp_err),
    .redir_valid   (redir_valid),
    .redir_pc      (redir_pc),
    .rf_we         (rf_we),
    .rf_waddr      (rf_waddr),
    .rf_wdata      (rf_wdata),
    .exc_valid     (exc_valid),
    .exc_cause     (exc_cause),
    .exc_pc        (exc_pc),
    .busy          (busy)
  );
endmodule

// File: tb/tbljmp_unit_tb.sv
module tbljmp_unit_tb;
  localparam int XLEN = 32;
  localparam int EB   = XLEN / 8;

  typedef struct {
    bit              is_exc;
    logic [3:0]      cause;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] tgt;
    bit              link;
    logic [XLEN-1:0] ra;
    string           tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic ext_en = 1, se_required = 0, se_bit = 1;
  logic ins_valid = 0; logic ins_ready;
  logic [15:0] ins_word = '0; logic [XLEN-1:0] ins_pc = '0;
  logic csr_req = 0, csr_wr = 0; logic [11:0] csr_addr = '0; logic [XLEN-1:0] csr_wdata = '0;
  logic csr_resp, csr_fault; logic [XLEN-1:0] csr_rdata;
  logic mem_req_valid, mem_req_ready = 0, mem_rsp_ready;
  logic [XLEN-1:0] mem_req_addr;
  logic mem_rsp_valid = 0, mem_rsp_err = 0; logic [XLEN-1:0] mem_rsp_data = '0;
  logic redir_valid, rf_we, exc_valid, busy;
  logic [XLEN-1:0] redir_pc, rf_wdata, exc_pc;
  logic [4:0] rf_waddr; logic [3:0] exc_cause;

  int checks = 0, errors = 0;
  int stall_left = 0, rsp_lat = 0;
  logic [XLEN-1:0] fault_addr = '1;
  exp_t            evq[$];
  logic [XLEN-1:0] addrq[$];

  always #2.5 clk = ~clk;

  tbljmp_unit #(.XLEN(XLEN)) u_dut (.*);

  function automatic logic [XLEN-1:0] entry_of(logic [XLEN-1:0] a);
    return a * 3 + 1;
  endfunction

  task automatic check(bit ok, string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: back-pressure, latency, fault injection, address check (R3)
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        if (stall_left > 0) begin
          stall_left--;
        end else begin
          logic [XLEN-1:0] ea;
          ea = (addrq.size() > 0) ? addrq.pop_front() : '1;
          check(mem_req_addr == ea, "R3", "table address", mem_req_addr, ea);
          mem_req_ready = 1;
          @(posedge clk); #1;
          mem_req_ready = 0;
          repeat (rsp_lat) @(posedge clk);
          if (rsp_lat > 0) #1;
          mem_rsp_valid = 1;
          mem_rsp_data  = entry_of(ea);
          mem_rsp_err   = (ea == fault_addr);
          @(posedge clk); #1;
          mem_rsp_valid = 0;
          mem_rsp_err   = 0;
        end
      end
    end
  end

  // monitor: scoreboard compare of every output pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (redir_valid || rf_we || exc_valid)) begin
        if (evq.size() == 0) begin
          check(0, "R1", "unexpected output pulse", {31'b0, redir_valid}, '0);
        end else begin
          exp_t e;
          e = evq.pop_front();
          if (e.is_exc) begin
            check(exc_valid && !redir_valid && !rf_we, e.tag, "exception only", {31'b0, exc_valid}, 1);
            check(exc_cause == e.cause, e.tag, "cause", XLEN'(exc_cause), XLEN'(e.cause));
            check(exc_pc == e.pc, e.tag, "exc pc", exc_pc, e.pc);
          end else begin
            check(redir_valid && !exc_valid, "R4", "redirect", {31'b0, redir_valid}, 1);
            check(redir_pc == e.tgt, "R4", "target bit0 cleared", redir_pc, e.tgt);
            check(rf_we == e.link, "R5", "link select", {31'b0, rf_we}, {31'b0, e.link});
            if (e.link) begin
              check(rf_waddr == 5'd1, "R5", "link reg", XLEN'(rf_waddr), 1);
              check(rf_wdata == e.ra, "R5", "return addr", rf_wdata, e.ra);
            end
          end
        end
      end
    end
  end

  task automatic csr_op(bit wr, logic [11:0] a, logic [XLEN-1:0] wd,
                        bit exp_resp, bit exp_fault, logic [XLEN-1:0] exp_rd, string req);
    @(posedge clk); #1;
    csr_req = 1; csr_wr = wr; csr_addr = a; csr_wdata = wd;
    @(posedge clk); #1;
    csr_req = 0; csr_wr = 0;
    check(csr_resp == exp_resp, req, "csr resp", {31'b0, csr_resp}, {31'b0, exp_resp});
    if (exp_resp) begin
      check(csr_fault == exp_fault, req, "csr fault", {31'b0, csr_fault}, {31'b0, exp_fault});
      check(csr_rdata == exp_rd, req, "csr rdata", csr_rdata, exp_rd);
    end
  endtask

  function automatic logic [15:0] tj_word(logic [7:0] idx);
    return {3'b101, 3'b000, idx, 2'b10};
  endfunction

  // driver: csr is the bench's model of the CSR contents; legal selects path
  task automatic send(logic [15:0] w, logic [XLEN-1:0] pc, logic [XLEN-1:0] csr, string tag);
    bit tj, legal;
    exp_t e;
    logic [XLEN-1:0] a;
    tj    = (w[15:10] == 6'b101000) && (w[1:0] == 2'b10);
    legal = ext_en && !(se_required && !se_bit) && (csr[5:0] == 0);
    a     = {csr[XLEN-1:6], 6'b0} + XLEN'(w[9:2]) * EB;
    @(posedge clk); #1;
    while (!ins_ready) begin @(posedge clk); #1; end
    if (tj) begin
      e.tag = tag; e.pc = pc; e.ra = pc + 2; e.link = (w[9:2] >= 32);
      if (!legal) begin
        e.is_exc = 1; e.cause = 4'd2;
      end else if (a == fault_addr) begin
        e.is_exc = 1; e.cause = 4'd1; addrq.push_back(a);
      end else begin
        e.is_exc = 0; e.tgt = entry_of(a) & ~XLEN'(1); addrq.push_back(a);
      end
      evq.push_back(e);
    end
    ins_valid = 1; ins_word = w; ins_pc = pc;
    @(posedge clk); #1;
    ins_valid = 0;
    if (tj && legal)
      check(busy && !ins_ready, "R10", "busy while in flight", {31'b0, busy}, 1);
    repeat (2) @(posedge clk);
    #1;
    while (!ins_ready) begin @(posedge clk); #1; end
    repeat (2) @(posedge clk);
    check(evq.size() == 0, tag, "result delivered", XLEN'(evq.size()), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11 reset state
    check(ins_ready && !busy, "R11", "idle after reset", {31'b0, ins_ready}, 1);
    check(!redir_valid && !rf_we && !exc_valid && !mem_req_valid, "R11", "no pulses", 0, 0);
    csr_op(0, 12'h017, '0, 1, 0, '0, "R11");
    // R2 csr write/read and other addresses
    csr_op(1, 12'h017, 32'h1000_0040, 1, 0, '0, "R2");
    csr_op(0, 12'h017, '0, 1, 0, 32'h1000_0040, "R2");
    csr_op(1, 12'h018, 32'hDEAD_0000, 0, 0, '0, "R2");
    csr_op(0, 12'h017, '0, 1, 0, 32'h1000_0040, "R2");
    // R1/R4/R5 jumps, boundaries of index
    send(tj_word(8'd5),   32'h0000_2000, 32'h1000_0040, "R4");
    send(tj_word(8'd31),  32'h0000_2010, 32'h1000_0040, "R5");
    send(tj_word(8'd32),  32'h0000_2020, 32'h1000_0040, "R5");
    send(tj_word(8'd0),   32'h0000_2030, 32'h1000_0040, "R4");
    // R3 back-pressure and latency, index 255
    stall_left = 4; rsp_lat = 3;
    send(tj_word(8'd255), 32'h0000_2040, 32'h1000_0040, "R3");
    rsp_lat = 0;
    // R1 non-matching words produce nothing
    send(16'hA402, 32'h0000_2050, 32'h1000_0040, "R1");
    send(16'hA001, 32'h0000_2060, 32'h1000_0040, "R1");
    send(16'h2002, 32'h0000_2070, 32'h1000_0040, "R1");
    // R9 access fault
    fault_addr = 32'h1000_0040 + 40 * EB;
    send(tj_word(8'd40), 32'h0000_3000, 32'h1000_0040, "R9");
    fault_addr = '1;
    // R6 nonzero mode, full value stored
    csr_op(1, 12'h017, 32'h2000_0083, 1, 0, 32'h1000_0040, "R2");
    csr_op(0, 12'h017, '0, 1, 0, 32'h2000_0083, "R2");
    send(tj_word(8'd33), 32'h0000_3100, 32'h2000_0083, "R6");
    csr_op(1, 12'h017, 32'h2000_0080, 1, 0, 32'h2000_0083, "R6");
    send(tj_word(8'd33), 32'h0000_3110, 32'h2000_0080, "R5");
    // R7 extension disabled
    ext_en = 0;
    csr_op(1, 12'h017, 32'h5555_5540, 1, 1, '0, "R7");
    send(tj_word(8'd7), 32'h0000_3200, 32'h2000_0080, "R7");
    ext_en = 1;
    csr_op(0, 12'h017, '0, 1, 0, 32'h2000_0080, "R7");
    // R8 state-enable gate
    se_required = 1; se_bit = 0;
    csr_op(1, 12'h017, 32'h6666_6600, 1, 1, '0, "R8");
    send(tj_word(8'd50), 32'h0000_3300, 32'h2000_0080, "R8");
    se_bit = 1;
    send(tj_word(8'd50), 32'h0000_3310, 32'h2000_0080, "R8");
    se_required = 0; se_bit = 0;
    send(tj_word(8'd2), 32'h0000_3320, 32'h2000_0080, "R8");
    csr_op(0, 12'h017, '0, 1, 0, 32'h2000_0080, "R8");
    check(addrq.size() == 0, "R6", "no stray memory request", XLEN'(addrq.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog expired actual=%h expected=%h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule